// File: doc/BRIEF.md
# Smart Card Channel Transmit Status Controller

This block keeps the status flags of one serial channel operating in smart card (half-duplex, error-signalling) mode and turns them into interrupt and DMA requests. The bit-level transmitter and receiver report character events as single-cycle strobes. Software, or a DMA engine, writes the transmit data register and reads the receive data register. A separate clear strobe from the register interface clears each sticky error flag. The block drives the transmit-empty, transmit-end, receive-full, overrun, parity and error-signal flags. From these it forms three level-sensitive requests: transmit, receive and error.

When the far end signals a parity error against a transmitted character, the block asks the serializer to resend the same byte. Transmit-end stays low and no DMA activation occurs until the byte is accepted. A programmable retry limit bounds this loop. Once the limit is spent, the channel reports end of transmission anyway, so a DMA-driven transfer cannot stall. The transmit-end interrupt that exists in the channel's normal mode is never raised here. A two-bit priority code gives the most urgent pending request, with error above receive above transmit.

Top module: `sc_txstat_ctrl`

## Requirements
- R1: After reset, txe_flag and tend_flag are 1, while rxf_flag, ovr_flag, par_flag, esig_flag and resend_req are 0.
- R2: A tx_done strobe sets txe_flag and tend_flag together on the following cycle and clears resend_req.
- R3: A tdr_wr strobe clears txe_flag and tend_flag on the following cycle. When tx_done arrives in the same cycle, the set wins and both flags read 1.
- R4: A tx_err strobe with retries remaining sets resend_req and esig_flag and forces txe_flag and tend_flag to 0. Transmit-end stays 0 while resend_req is 1.
- R5: dma_tx_req is 0 whenever resend_req is 1.
- R6: esig_flag is cleared only by clr_esig. A tx_err in the same cycle as clr_esig leaves it set.
- R7: With retry_limit = N, the first N consecutive tx_err strobes each request a resend. The next tx_err sets txe_flag and tend_flag, clears resend_req and leaves esig_flag at 1. With N = 0, the first error gives up at once.
- R8: A clean rx_done sets rxf_flag. An rx_done with rx_par and rxf_flag at 0 sets par_flag instead. An rx_done while rxf_flag is 1 (and no rdr_rd in that cycle) sets ovr_flag and keeps rxf_flag. rdr_rd clears rxf_flag, clr_ovr clears ovr_flag and clr_par clears par_flag.
- R9: The request outputs are levels: txi_req = tend_flag and txi_en; rxi_req = rxf_flag and rxi_en; eri_req = (ovr_flag or par_flag or esig_flag) and rxi_en; dma_tx_req = txi_req and not resend_req.
- R10: irq_code is 3 when eri_req is 1, otherwise 2 when rxi_req is 1, otherwise 1 when txi_req is 1, otherwise 0.
- R11: tei_req stays 0 whatever the value of tei_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tdr_wr | input | 1 | Transmit data register written (CPU or DMA) |
| tx_done | input | 1 | Transmitted character accepted without error signal |
| tx_err | input | 1 | Error signal seen at the end of a transmitted character |
| rx_done | input | 1 | Received character complete |
| rx_par | input | 1 | Parity error on the character qualified by rx_done |
| rdr_rd | input | 1 | Receive data register read |
| clr_ovr | input | 1 | Clear the overrun flag |
| clr_par | input | 1 | Clear the parity flag |
| clr_esig | input | 1 | Clear the error-signal flag |
| txi_en | input | 1 | Transmit request enable |
| rxi_en | input | 1 | Receive and error request enable |
| tei_en | input | 1 | Transmit-end request enable (has no effect in this mode) |
| retry_limit | input | RW | Maximum number of automatic resends |
| txe_flag | output | 1 | Transmit data empty |
| tend_flag | output | 1 | Transmit end |
| rxf_flag | output | 1 | Receive data full |
| ovr_flag | output | 1 | Overrun |
| par_flag | output | 1 | Parity error |
| esig_flag | output | 1 | Error signal status |
| resend_req | output | 1 | Serializer must resend the current byte |
| txi_req | output | 1 | Transmit request |
| rxi_req | output | 1 | Receive request |
| eri_req | output | 1 | Error request |
| tei_req | output | 1 | Transmit-end request, held 0 |
| dma_tx_req | output | 1 | DMA activation for transmit |
| irq_code | output | 2 | Highest-priority pending request |

## Verification
The bench targets the collisions between strobes. A design that lets a clear beat a coincident set would lose a completed character or an error-signal report. A design that counts the retry limit off by one would resend once too often or give up one error early, and the limit of zero shows whether the compare is inclusive. The bench checks that DMA activation stays off during a retry, which catches a design that drives DMA from transmit-empty alone. It also sets an overrun while the receive flag is full, to catch a design that overwrites rxf_flag or raises a parity error for a character that was dropped.

// File: rtl/sc_txstat_pkg.sv
package sc_txstat_pkg;

    // priority code of the pending request, larger is more urgent
    typedef enum logic [1:0] {
        IRQ_NONE = 2'd0,
        IRQ_TXI  = 2'd1,
        IRQ_RXI  = 2'd2,
        IRQ_ERI  = 2'd3
    } irq_code_e;

    localparam int unsigned NUM_REQ = 3;

    typedef struct packed {
        logic rxf;
        logic ovr;
        logic par;
    } rx_flags_t;

endpackage

// File: rtl/sc_tx_track.sv
module sc_tx_track #(
    parameter int unsigned RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tdr_wr,
    input  logic          tx_done,
    input  logic          tx_err,
    input  logic          clr_esig,
    input  logic [RW-1:0] retry_limit,
    output logic          txe,
    output logic          tend,
    output logic          esig,
    output logic          resend
);

    typedef struct packed {
        logic          txe;
        logic          tend;
        logic          esig;
        logic          resend;
        logic [RW-1:0] cnt;
    } tx_state_t;

    localparam logic [RW-1:0] CNT_ONE = RW'(1);

    tx_state_t st_d, st_q;
    logic      limit_hit;

    assign limit_hit = (st_q.cnt >= retry_limit);

    always_comb begin
        st_d = st_q;
        // register-side clears first, character events override them
        if (tdr_wr) begin
            st_d.txe  = 1'b0;
            st_d.tend = 1'b0;
        end
        if (clr_esig) begin
            st_d.esig = 1'b0;
        end
        if (tx_done) begin
            st_d.txe    = 1'b1;
            st_d.tend   = 1'b1;
            st_d.resend = 1'b0;
            st_d.cnt    = '0;
        end else if (tx_err) begin
            st_d.esig = 1'b1;
            if (limit_hit) begin
                // retries spent: report end so the channel moves on
                st_d.txe    = 1'b1;
                st_d.tend   = 1'b1;
                st_d.resend = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.txe    = 1'b0;
                st_d.tend   = 1'b0;
                st_d.resend = 1'b1;
                st_d.cnt    = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.txe    <= 1'b1;
            st_q.tend   <= 1'b1;
            st_q.esig   <= 1'b0;
            st_q.resend <= 1'b0;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txe    = st_q.txe;
    assign tend   = st_q.tend;
    assign esig   = st_q.esig;
    assign resend = st_q.resend;

endmodule

// File: rtl/sc_rx_track.sv
module sc_rx_track
    import sc_txstat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_done,
    input  logic      rx_par,
    input  logic      rdr_rd,
    input  logic      clr_ovr,
    input  logic      clr_par,
    output rx_flags_t flags
);

    rx_flags_t fl_d, fl_q;
    logic      still_full;

    // data still unread at the moment a new character lands
    assign still_full = fl_q.rxf && !rdr_rd;

    always_comb begin
        fl_d = fl_q;
        if (rdr_rd)  fl_d.rxf = 1'b0;
        if (clr_ovr) fl_d.ovr = 1'b0;
        if (clr_par) fl_d.par = 1'b0;
        if (rx_done) begin
            if (still_full) begin
                fl_d.ovr = 1'b1;
            end else if (rx_par) begin
                fl_d.par = 1'b1;
            end else begin
                fl_d.rxf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

endmodule

// File: rtl/sc_req_arb.sv
module sc_req_arb
    import sc_txstat_pkg::*;
(
    input  logic       tend,
    input  logic       resend,
    input  logic       esig,
    input  rx_flags_t  rxfl,
    input  logic       txi_en,
    input  logic       rxi_en,
    input  logic       tei_en,
    output logic       txi_req,
    output logic       rxi_req,
    output logic       eri_req,
    output logic       tei_req,
    output logic       dma_tx_req,
    output logic [1:0] irq_code
);

    logic [NUM_REQ-1:0] req_vec;
    irq_code_e          code;
    logic               tei_unused;

    assign txi_req    = tend && txi_en;
    assign rxi_req    = rxfl.rxf && rxi_en;
    assign eri_req    = (rxfl.ovr || rxfl.par || esig) && rxi_en;
    // transmit-end request does not exist in this mode
    assign tei_unused = tei_en;
    assign tei_req    = 1'b0;
    assign dma_tx_req = txi_req && !resend;

    // index 0 = TXI, 1 = RXI, 2 = ERI; highest set index wins
    assign req_vec = {eri_req, rxi_req, txi_req};

    always_comb begin
        code = IRQ_NONE;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req_vec[i]) code = irq_code_e'(i + 1);
        end
    end

    assign irq_code = code;

endmodule

// File: rtl/sc_txstat_ctrl.sv
module sc_txstat_ctrl
    import sc_txstat_pkg::*;
#(
    parameter int unsigned RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tdr_wr,
    input  logic          tx_done,
    input  logic          tx_err,
    input  logic          rx_done,
    input  logic          rx_par,
    input  logic          rdr_rd,
    input  logic          clr_ovr,
    input  logic          clr_par,
    input  logic          clr_esig,
    input  logic          txi_en,
    input  logic          rxi_en,
    input  logic          tei_en,
    input  logic [RW-1:0] retry_limit,
    output logic          txe_flag,
    output logic          tend_flag,
    output logic          rxf_flag,
    output logic          ovr_flag,
    output logic          par_flag,
    output logic          esig_flag,
    output logic          resend_req,
    output logic          txi_req,
    output logic          rxi_req,
    output logic          eri_req,
    output logic          tei_req,
    output logic          dma_tx_req,
    output logic [1:0]    irq_code
);

    rx_flags_t rxfl;

    sc_tx_track #(.RW(RW)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tdr_wr      (tdr_wr),
        .tx_done     (tx_done),
        .tx_err      (tx_err),
        .clr_esig    (clr_esig),
        .retry_limit (retry_limit),
        .txe         (txe_flag),
        .tend        (tend_flag),
        .esig        (esig_flag),
        .resend      (resend_req)
    );

    sc_rx_track rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_done (rx_done),
        .rx_par  (rx_par),
        .rdr_rd  (rdr_rd),
        .clr_ovr (clr_ovr),
        .clr_par (clr_par),
        .flags   (rxfl)
    );

    sc_req_arb arb_i (
        .tend       (tend_flag),
        .resend     (resend_req),
        .esig       (esig_flag),
        .rxfl       (rxfl),
        .txi_en     (txi_en),
        .rxi_en     (rxi_en),
        .tei_en     (tei_en),
        .txi_req    (txi_req),
        .rxi_req    (rxi_req),
        .eri_req    (eri_req),
        .tei_req    (tei_req),
        .dma_tx_req (dma_tx_req),
        .irq_code   (irq_code)
    );

    assign rxf_flag = rxfl.rxf;
    assign ovr_flag = rxfl.ovr;
    assign par_flag = rxfl.par;

endmodule

// File: rtl/sc_txstat_chk.sv
module sc_txstat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tdr_wr,
    input logic       tx_done,
    input logic       tx_err,
    input logic       rx_done,
    input logic       rx_par,
    input logic       clr_esig,
    input logic       txe_flag,
    input logic       tend_flag,
    input logic       rxf_flag,
    input logic       esig_flag,
    input logic       resend_req,
    input logic       eri_req,
    input logic       dma_tx_req,
    input logic [1:0] irq_code
);

    AST_DONE_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> (txe_flag && tend_flag)); // R2

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_wr && !tx_done && !tx_err) |=> (!txe_flag && !tend_flag)); // R3

    AST_RETRY_HOLDS_TEND: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |-> !tend_flag); // R4

    AST_NO_DMA_IN_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |-> !dma_tx_req); // R5

    AST_ESIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (esig_flag && !clr_esig) |=> esig_flag); // R6

    AST_ERR_SETS_ESIG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && !tx_done) |=> esig_flag); // R6

    AST_RX_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_par && !rxf_flag) |=> rxf_flag); // R8

    AST_ERI_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        eri_req |-> (irq_code == 2'd3)); // R10

endmodule

bind sc_txstat_ctrl sc_txstat_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tdr_wr     (tdr_wr),
    .tx_done    (tx_done),
    .tx_err     (tx_err),
    .rx_done    (rx_done),
    .rx_par     (rx_par),
    .clr_esig   (clr_esig),
    .txe_flag   (txe_flag),
    .tend_flag  (tend_flag),
    .rxf_flag   (rxf_flag),
    .esig_flag  (esig_flag),
    .resend_req (resend_req),
    .eri_req    (eri_req),
    .dma_tx_req (dma_tx_req),
    .irq_code   (irq_code)
);

// File: tb/sc_txstat_ctrl_tb_top.sv
`timescale 1ns/1ps
module sc_txstat_ctrl_tb_top;

    localparam int unsigned RW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tdr_wr = 0, tx_done = 0, tx_err = 0, rx_done = 0, rx_par = 0;
    logic rdr_rd = 0, clr_ovr = 0, clr_par = 0, clr_esig = 0;
    logic txi_en = 1, rxi_en = 1, tei_en = 0;
    logic [RW-1:0] retry_limit = RW'(3);
    logic txe_flag, tend_flag, rxf_flag, ovr_flag, par_flag, esig_flag, resend_req;
    logic txi_req, rxi_req, eri_req, tei_req, dma_tx_req;
    logic [1:0] irq_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    sc_txstat_ctrl #(.RW(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tdr_wr(tdr_wr), .tx_done(tx_done), .tx_err(tx_err),
        .rx_done(rx_done), .rx_par(rx_par), .rdr_rd(rdr_rd), .clr_ovr(clr_ovr),
        .clr_par(clr_par), .clr_esig(clr_esig), .txi_en(txi_en), .rxi_en(rxi_en),
        .tei_en(tei_en), .retry_limit(retry_limit), .txe_flag(txe_flag),
        .tend_flag(tend_flag), .rxf_flag(rxf_flag), .ovr_flag(ovr_flag),
        .par_flag(par_flag), .esig_flag(esig_flag), .resend_req(resend_req),
        .txi_req(txi_req), .rxi_req(rxi_req), .eri_req(eri_req), .tei_req(tei_req),
        .dma_tx_req(dma_tx_req), .irq_code(irq_code)
    );

    // stimulus {tdr_wr,tx_done,tx_err,rx_done,rx_par,rdr_rd,clr_ovr,clr_par,clr_esig}
    // expect   {txe,tend,rxf,ovr,par,esig,resend}
    localparam int NV = 15;
    localparam logic [15:0] VEC [NV] = '{
        {9'b100000000, 7'b0000000},
        {9'b010000000, 7'b1100000},
        {9'b100000000, 7'b0000000},
        {9'b001000000, 7'b0000011},
        {9'b010000000, 7'b1100010},
        {9'b000000001, 7'b1100000},
        {9'b000100000, 7'b1110000},
        {9'b000100000, 7'b1111000},
        {9'b000001000, 7'b1101000},
        {9'b000110000, 7'b1101100},
        {9'b000000110, 7'b1100000},
        {9'b110000000, 7'b1100000},
        {9'b001000001, 7'b0000011},
        {9'b010000000, 7'b1100010},
        {9'b000000001, 7'b1100000}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // apply one cycle of strobes at a falling edge, return after the next falling edge
    task automatic step(input logic [8:0] s);
        {tdr_wr, tx_done, tx_err, rx_done, rx_par, rdr_rd, clr_ovr, clr_par, clr_esig} = s;
        @(negedge clk);
        {tdr_wr, tx_done, tx_err, rx_done, rx_par, rdr_rd, clr_ovr, clr_par, clr_esig} = '0;
    endtask

    function automatic logic [1:0] exp_code(input logic e, input logic r, input logic t);
        if (e) return 2'd3;
        if (r) return 2'd2;
        if (t) return 2'd1;
        return 2'd0;
    endfunction

    task automatic check_flags(input string rq, input logic [6:0] e);
        chk(rq, {txe_flag, tend_flag, rxf_flag, ovr_flag, par_flag, esig_flag, resend_req}, e);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_flags("R1 reset", 7'b1100000);
        rst_n = 1'b1;
        @(negedge clk);
        check_flags("R1 after release", 7'b1100000);

        // vector table, enables all on, limit 3 (R2 R3 R4 R6 R8 R9 R10)
        for (int i = 0; i < NV; i++) begin
            logic [6:0] e;
            e = VEC[i][6:0];
            step(VEC[i][15:7]);
            check_flags($sformatf("R2/R3/R4/R6/R8 vec %0d", i), e);
            chk("R9 txi", txi_req, e[5]);
            chk("R9 rxi", rxi_req, e[4]);
            chk("R9 eri", eri_req, e[3] | e[2] | e[1]);
            chk("R10 code", irq_code, exp_code(e[3] | e[2] | e[1], e[4], e[5]));
            chk("R5 dma", dma_tx_req, e[5] & ~e[0]);
        end

        // R7 retry limit 3: three resends, the fourth error gives up
        step(9'b100000000);
        for (int k = 0; k < 3; k++) begin
            step(9'b001000000);
            check_flags("R7 retry", 7'b0000011);
            chk("R5 dma held during retry", dma_tx_req, 1'b0);
        end
        step(9'b001000000);
        check_flags("R7 give up", 7'b1100010);
        chk("R7 dma after give up", dma_tx_req, 1'b1);
        step(9'b000000001);

        // R7 limit 0
        retry_limit = '0;
        step(9'b100000000);
        step(9'b001000000);
        check_flags("R7 limit zero", 7'b1100010);
        step(9'b000000001);
        retry_limit = RW'(3);

        // R10 priority walk
        chk("R10 txi only", irq_code, 2'd1);
        step(9'b000100000);
        chk("R10 rxi over txi", irq_code, 2'd2);
        step(9'b001000000);
        chk("R10 eri on top", irq_code, 2'd3);
        step(9'b000000001);
        chk("R10 rxi after err clear", irq_code, 2'd2);
        step(9'b000001000);
        chk("R10 none during retry", irq_code, 2'd0);
        step(9'b010000000);
        chk("R10 txi back", irq_code, 2'd1);

        // R9 enables gate requests
        txi_en = 1'b0;
        #1;
        chk("R9 txi gated", txi_req, 1'b0);
        chk("R10 code none", irq_code, 2'd0);
        rxi_en = 1'b0;
        step(9'b000100000);
        chk("R9 rxi gated", rxi_req, 1'b0);
        step(9'b000100000);
        chk("R8 overrun set", ovr_flag, 1'b1);
        chk("R9 eri gated", eri_req, 1'b0);
        rxi_en = 1'b1;
        #1;
        chk("R9 eri enabled", eri_req, 1'b1);

        // R11 transmit-end request never raised
        tei_en = 1'b1;
        txi_en = 1'b1;
        #1;
        chk("R11 tei with enable", tei_req, 1'b0);
        step(9'b100000000);
        step(9'b010000000);
        chk("R11 tei after end", tei_req, 1'b0);

        // R1 reset mid-run
        step(9'b001000000);
        rst_n = 1'b0;
        #1;
        check_flags("R1 mid-run reset", 7'b1100000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule